// File: doc/BRIEF.md
# Platform System Control Register Block

This block is a byte-wide register file that sits on a simple I/O bus. It answers a single special port at 0x092 and a sparse bank of ports between 0x800 and 0x851. Most of the readable ports return fixed identity and feature bytes that describe the platform. A few ports hold writable control fields: the byte-order mode, the disk activity light, a 4-bit system control value and the I/O map type.

Some ports do not store anything. A write to them instead produces a single-cycle request pulse for a neighbouring unit: a soft reset, an L2 cache invalidate, or one of the two NVRAM password-lock toggles. Those neighbouring units only receive the pulses and are not part of this block.

The bus side has an address, a write strobe, a read strobe and write data. Read data is registered. A read of any port the block does not answer returns all ones. A write to any port that has no write meaning raises a one-cycle error flag.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, `le_mode`, `disk_led`, `sys_ctrl`, `map_sparse`, every request pulse, `wr_err` and `rd_data` are all 0.
- R2: A write to port 0x092 pulses `soft_rst_req` when data bit 0 is 1 and loads `le_mode` from data bit 1. A read of 0x092 returns 0x00.
- R3: Reads of the identity ports return fixed bytes: 0x800→0xEF, 0x802→0xAD, 0x803→0xE0, 0x80C→0x3C, 0x810→0x39, 0x818→0x00, 0x823→0x03.
- R4: A write to 0x800, 0x802 or 0x803 changes no output. It raises no pulse and no `wr_err`, and a later read of the port still gives its fixed byte.
- R5: A write to 0x808 loads `disk_led` from data bit 0.
- R6: A write to 0x810 pulses `lock1_req` and a write to 0x812 pulses `lock2_req`, whatever the data value.
- R7: A write to 0x814 pulses `l2_inval_req`. A read of 0x814 returns 0xFF.
- R8: A write to 0x81C stores data bits 3:0 in `sys_ctrl`. A read of 0x81C returns that value in bits 3:0, with bits 7:4 at zero.
- R9: A write to 0x850 stores data bit 0 in `map_sparse`. A read of 0x850 returns it in bit 0, with all other bits at zero.
- R10: A read of any port not listed in R2, R3, R7, R8 or R9 returns 0xFF. This includes 0x808 and 0x812.
- R11: A write to any port not listed in R2 and R4 to R9 pulses `wr_err` for one cycle and changes no control field.
- R12: Control fields, pulses and `rd_data` all change on the first clock edge after the access is sampled. Each pulse lasts exactly one cycle per write. `rd_data` holds its value on cycles with no read. A read that coincides with a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity light |
| sys_ctrl | output | CTRL_W | System control value |
| map_sparse | output | 1 | I/O map type (1 = sparse) |
| soft_rst_req | output | 1 | Soft reset request pulse |
| l2_inval_req | output | 1 | L2 invalidate request pulse |
| lock1_req | output | 1 | NVRAM lock toggle 1 pulse |
| lock2_req | output | 1 | NVRAM lock toggle 2 pulse |
| wr_err | output | 1 | Write to undecoded port, one-cycle pulse |

## Verification
The bench builds the block with its defaults: ADDR_W = 16 and CTRL_W = 4. The 16-bit address lets the bench reach every decoded port. It can also reach holes inside the bank, such as 0x801, 0x812 for reads and 0x851, and ports just outside it, such as 0x093 and 0x7FF. With a 4-bit control field, the bench can show that writing 0xA5 to 0x81C drops the high nibble, both in `sys_ctrl` and on readback.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  // Decoded port addresses (the platform's software depends on these)
  localparam logic [15:0] A_SPECIAL = 16'h0092;
  localparam logic [15:0] A_CPUCFG  = 16'h0800;
  localparam logic [15:0] A_FEAT    = 16'h0802;
  localparam logic [15:0] A_STAT    = 16'h0803;
  localparam logic [15:0] A_LED     = 16'h0808;
  localparam logic [15:0] A_EQUIP   = 16'h080C;
  localparam logic [15:0] A_LOCK1   = 16'h0810;
  localparam logic [15:0] A_LOCK2   = 16'h0812;
  localparam logic [15:0] A_L2INV   = 16'h0814;
  localparam logic [15:0] A_KEY     = 16'h0818;
  localparam logic [15:0] A_SYSCTL  = 16'h081C;
  localparam logic [15:0] A_L2STAT  = 16'h0823;
  localparam logic [15:0] A_MAP     = 16'h0850;

  // Fixed identity bytes
  localparam logic [7:0] V_CPUCFG = 8'hEF;
  localparam logic [7:0] V_FEAT   = 8'hAD;
  localparam logic [7:0] V_STAT   = 8'hE0;
  localparam logic [7:0] V_EQUIP  = 8'h3C;
  localparam logic [7:0] V_EXTF   = 8'h39;
  localparam logic [7:0] V_KEY    = 8'h00;
  localparam logic [7:0] V_L2STAT = 8'h03;
  localparam logic [7:0] V_EMPTY  = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SPECIAL, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_LED,
    SEL_EQUIP, SEL_LOCK1, SEL_LOCK2, SEL_L2INV, SEL_KEY, SEL_SYSCTL,
    SEL_L2STAT, SEL_MAP
  } port_sel_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel,
  output logic              wr_known
);
  localparam int CMP_W = (ADDR_W < 16) ? ADDR_W : 16;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [15:0] p);
    logic [ADDR_W-1:0] ext;
    ext = '0;
    ext[CMP_W-1:0] = p[CMP_W-1:0];
    return a == ext;
  endfunction

  always_comb begin
    sel = SEL_NONE;
    if      (hit(addr, A_SPECIAL)) sel = SEL_SPECIAL;
    else if (hit(addr, A_CPUCFG))  sel = SEL_CPUCFG;
    else if (hit(addr, A_FEAT))    sel = SEL_FEAT;
    else if (hit(addr, A_STAT))    sel = SEL_STAT;
    else if (hit(addr, A_LED))     sel = SEL_LED;
    else if (hit(addr, A_EQUIP))   sel = SEL_EQUIP;
    else if (hit(addr, A_LOCK1))   sel = SEL_LOCK1;
    else if (hit(addr, A_LOCK2))   sel = SEL_LOCK2;
    else if (hit(addr, A_L2INV))   sel = SEL_L2INV;
    else if (hit(addr, A_KEY))     sel = SEL_KEY;
    else if (hit(addr, A_SYSCTL))  sel = SEL_SYSCTL;
    else if (hit(addr, A_L2STAT))  sel = SEL_L2STAT;
    else if (hit(addr, A_MAP))     sel = SEL_MAP;
  end

  always_comb begin
    case (sel)
      SEL_SPECIAL, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_LED,
      SEL_LOCK1, SEL_LOCK2, SEL_L2INV, SEL_SYSCTL, SEL_MAP: wr_known = 1'b1;
      default: wr_known = 1'b0;
    endcase
  end
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  port_sel_e         sel,
  input  logic              wr_known,
  input  logic [7:0]        wr_data,
  output logic              le_mode,
  output logic              disk_led,
  output logic [CTRL_W-1:0] sys_ctrl,
  output logic              map_sparse,
  output logic              soft_rst_req,
  output logic              l2_inval_req,
  output logic              lock1_req,
  output logic              lock2_req,
  output logic              wr_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      le_mode      <= 1'b0;
      disk_led     <= 1'b0;
      sys_ctrl     <= '0;
      map_sparse   <= 1'b0;
      soft_rst_req <= 1'b0;
      l2_inval_req <= 1'b0;
      lock1_req    <= 1'b0;
      lock2_req    <= 1'b0;
      wr_err       <= 1'b0;
    end else begin
      soft_rst_req <= wr_en && sel == SEL_SPECIAL && wr_data[0];
      l2_inval_req <= wr_en && sel == SEL_L2INV;
      lock1_req    <= wr_en && sel == SEL_LOCK1;
      lock2_req    <= wr_en && sel == SEL_LOCK2;
      wr_err       <= wr_en && !wr_known;
      if (wr_en) begin
        case (sel)
          SEL_SPECIAL: le_mode    <= wr_data[1];
          SEL_LED:     disk_led   <= wr_data[0];
          SEL_SYSCTL:  sys_ctrl   <= wr_data[CTRL_W-1:0];
          SEL_MAP:     map_sparse <= wr_data[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  port_sel_e         sel,
  input  logic [CTRL_W-1:0] sys_ctrl,
  input  logic              map_sparse,
  output logic [7:0]        rd_data
);
  logic [7:0] nxt;

  always_comb begin
    case (sel)
      SEL_SPECIAL: nxt = 8'h00;
      SEL_CPUCFG:  nxt = V_CPUCFG;
      SEL_FEAT:    nxt = V_FEAT;
      SEL_STAT:    nxt = V_STAT;
      SEL_EQUIP:   nxt = V_EQUIP;
      SEL_LOCK1:   nxt = V_EXTF;
      SEL_KEY:     nxt = V_KEY;
      SEL_L2STAT:  nxt = V_L2STAT;
      SEL_SYSCTL: begin
        nxt = '0;
        nxt[CTRL_W-1:0] = sys_ctrl;
      end
      SEL_MAP:     nxt = {7'b0, map_sparse};
      default:     nxt = V_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= nxt;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              le_mode,
  output logic              disk_led,
  output logic [CTRL_W-1:0] sys_ctrl,
  output logic              map_sparse,
  output logic              soft_rst_req,
  output logic              l2_inval_req,
  output logic              lock1_req,
  output logic              lock2_req,
  output logic              wr_err
);
  port_sel_e sel;
  logic      wr_known;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .sel(sel), .wr_known(wr_known)
  );

  sysctl_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wr_known(wr_known),
    .wr_data(wr_data), .le_mode(le_mode), .disk_led(disk_led),
    .sys_ctrl(sys_ctrl), .map_sparse(map_sparse),
    .soft_rst_req(soft_rst_req), .l2_inval_req(l2_inval_req),
    .lock1_req(lock1_req), .lock2_req(lock2_req), .wr_err(wr_err)
  );

  sysctl_rdmux #(.CTRL_W(CTRL_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .sys_ctrl(sys_ctrl),
    .map_sparse(map_sparse), .rd_data(rd_data)
  );
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int ADDR_W = 16,
  parameter int CTRL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              le_mode,
  input logic              disk_led,
  input logic [CTRL_W-1:0] sys_ctrl,
  input logic              map_sparse,
  input logic              soft_rst_req,
  input logic              l2_inval_req,
  input logic              lock1_req,
  input logic              lock2_req,
  input logic              wr_err
);
  // R2
  soft_rst_src_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |-> ($past(wr_en) && $past(addr) == ADDR_W'(16'h0092) && $past(wr_data[0])));

  // R6
  lock1_src_chk: assert property (@(posedge clk) disable iff (rst)
    lock1_req |-> ($past(wr_en) && $past(addr) == ADDR_W'(16'h0810)));

  // R7
  l2inv_src_chk: assert property (@(posedge clk) disable iff (rst)
    l2_inval_req |-> ($past(wr_en) && $past(addr) == ADDR_W'(16'h0814)));

  // R11
  wr_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en));

  // R11
  wr_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> ($stable(le_mode) && $stable(disk_led) && $stable(sys_ctrl) && $stable(map_sparse)));

  // R12
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({soft_rst_req, l2_inval_req, lock1_req, lock2_req, wr_err}));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));

  // R8
  sysctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr) == ADDR_W'(16'h081C)) |-> sys_ctrl == $past(wr_data[CTRL_W-1:0]));

  // R3
  cpucfg_id_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == ADDR_W'(16'h0800)) |-> rd_data == 8'hEF);
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .le_mode(le_mode), .disk_led(disk_led),
  .sys_ctrl(sys_ctrl), .map_sparse(map_sparse), .soft_rst_req(soft_rst_req),
  .l2_inval_req(l2_inval_req), .lock1_req(lock1_req), .lock2_req(lock2_req),
  .wr_err(wr_err)
);

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CTRL_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic le_mode, disk_led, map_sparse;
  logic [CTRL_W-1:0] sys_ctrl;
  logic soft_rst_req, l2_inval_req, lock1_req, lock2_req, wr_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .le_mode(le_mode),
    .disk_led(disk_led), .sys_ctrl(sys_ctrl), .map_sparse(map_sparse),
    .soft_rst_req(soft_rst_req), .l2_inval_req(l2_inval_req),
    .lock1_req(lock1_req), .lock2_req(lock2_req), .wr_err(wr_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // pulses packed as {soft, l2, lock1, lock2, err}
  function automatic logic [7:0] pulses();
    return {3'b0, soft_rst_req, l2_inval_req, lock1_req, lock2_req, wr_err};
  endfunction

  function automatic logic [7:0] fields();
    return {1'b0, le_mode, disk_led, map_sparse, sys_ctrl};
  endfunction

  // write; returns at the negedge after the capturing edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 fields", fields(), 8'h00);
    chk("R1 pulses", pulses(), 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_special();
    logic [7:0] q;
    wr(16'h0092, 8'h03);
    chk("R2 soft reset pulse", pulses(), 8'h10);
    chk("R2 le_mode set", {7'b0, le_mode}, 8'h01);
    @(negedge clk);
    chk("R12 pulse one cycle", pulses(), 8'h00);
    wr(16'h0092, 8'h00);
    chk("R2 no pulse bit0=0", pulses(), 8'h00);
    chk("R2 le_mode clear", {7'b0, le_mode}, 8'h00);
    wr(16'h0092, 8'h02);
    rd(16'h0092, q);
    chk("R2 read 0x92", q, 8'h00);
  endtask

  task automatic t_ids();
    logic [7:0] q;
    rd(16'h0800, q); chk("R3 0x800", q, 8'hEF);
    rd(16'h0802, q); chk("R3 0x802", q, 8'hAD);
    rd(16'h0803, q); chk("R3 0x803", q, 8'hE0);
    rd(16'h080C, q); chk("R3 0x80C", q, 8'h3C);
    rd(16'h0810, q); chk("R3 0x810", q, 8'h39);
    rd(16'h0818, q); chk("R3 0x818", q, 8'h00);
    rd(16'h0823, q); chk("R3 0x823", q, 8'h03);
    @(negedge clk);
    chk("R12 rd_data holds", rd_data, 8'h03);
  endtask

  task automatic t_readonly();
    logic [7:0] q;
    logic [7:0] f;
    f = fields();
    wr(16'h0800, 8'h00); chk("R4 0x800 no pulse", pulses(), 8'h00);
    wr(16'h0802, 8'hFF); chk("R4 0x802 no pulse", pulses(), 8'h00);
    wr(16'h0803, 8'h55); chk("R4 0x803 no pulse", pulses(), 8'h00);
    chk("R4 fields unchanged", fields(), f);
    rd(16'h0802, q); chk("R4 0x802 still fixed", q, 8'hAD);
  endtask

  task automatic t_led();
    logic [7:0] q;
    wr(16'h0808, 8'hFF); chk("R5 led on", {7'b0, disk_led}, 8'h01);
    wr(16'h0808, 8'hFE); chk("R5 led off", {7'b0, disk_led}, 8'h00);
    rd(16'h0808, q); chk("R10 0x808 read", q, 8'hFF);
  endtask

  task automatic t_strobes();
    logic [7:0] q;
    wr(16'h0810, 8'h00); chk("R6 lock1", pulses(), 8'h04);
    wr(16'h0812, 8'hC3); chk("R6 lock2", pulses(), 8'h02);
    wr(16'h0814, 8'h00); chk("R7 l2 inval", pulses(), 8'h08);
    @(negedge clk);      chk("R12 l2 pulse drops", pulses(), 8'h00);
    rd(16'h0814, q);     chk("R7 0x814 read", q, 8'hFF);
    rd(16'h0812, q);     chk("R10 0x812 read", q, 8'hFF);
  endtask

  task automatic t_sysctl();
    logic [7:0] q;
    wr(16'h081C, 8'hA5);
    chk("R8 sys_ctrl low nibble", {4'b0, sys_ctrl}, 8'h05);
    rd(16'h081C, q); chk("R8 0x81C read", q, 8'h05);
    // simultaneous read and write returns old value
    @(negedge clk);
    addr = 16'h081C; wr_data = 8'h0C; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 read-with-write old value", rd_data, 8'h05);
    chk("R8 new value stored", {4'b0, sys_ctrl}, 8'h0C);
  endtask

  task automatic t_map();
    logic [7:0] q;
    wr(16'h0850, 8'hFF); chk("R9 map set", {7'b0, map_sparse}, 8'h01);
    rd(16'h0850, q);     chk("R9 0x850 read", q, 8'h01);
    wr(16'h0850, 8'h02); chk("R9 map clear", {7'b0, map_sparse}, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] q;
    logic [7:0] f;
    rd(16'h0801, q); chk("R10 0x801", q, 8'hFF);
    rd(16'h0851, q); chk("R10 0x851", q, 8'hFF);
    rd(16'h0093, q); chk("R10 0x093", q, 8'hFF);
    f = fields();
    wr(16'h081D, 8'hFF); chk("R11 err 0x81D", pulses(), 8'h01);
    @(negedge clk);      chk("R11 err drops", pulses(), 8'h00);
    wr(16'h07FF, 8'hFF); chk("R11 err 0x7FF", pulses(), 8'h01);
    wr(16'h080C, 8'h00); chk("R11 err 0x80C", pulses(), 8'h01);
    chk("R11 fields unchanged", fields(), f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_special();
    t_ids();
    t_readonly();
    t_led();
    t_strobes();
    t_sysctl();
    t_map();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule